// File: doc/BRIEF.md
# Transmit Channel-Status Block Shifter

This block supplies the channel-status bit for each frame of a digital audio transmitter. Software places a 192-bit status block into six 32-bit words, indexed 0 to 5 and called A to F. The transmitter pulses a frame-boundary strobe once per frame. On each strobe the block moves to the next status bit, so that every frame carries exactly one bit. The subframe builder uses that bit in both subframes of the frame.

The words are double-buffered. A register write lands in a shadow word. The shadow word is copied into the internal shifter only when the sequence reaches that word. A write therefore never disturbs the word currently going out.

A block-start marker tells the downstream logic when to choose the block-start preamble. A busy flag reports that a status block is being sent. The flag is set when word A is loaded and cleared when word F is loaded. It is also cleared when transmission stops.

Top module: `cs_block_shifter`

## Requirements
- R1: After reset, `cs_bit`, `block_start` and `cs_busy` are 0 and all six shadow words are 0.
- R2: Within a word, bits go out LSB first. The bit changes only on a clock edge that sees `frame_strobe` high, and the new bit appears in the cycle after that edge. Strobes in consecutive cycles advance one bit each.
- R3: After 32 frames of a word, the next word is loaded in index order 0 (A) to 5 (F). After bit 31 of F, the sequence wraps back to bit 0 of A and repeats without a gap.
- R4: When idle, a strobe edge with both `tx_en` and `cs_en` high loads word A. Bit 0 of A is output from the next cycle. With either enable low, a strobe starts nothing and `cs_bit` stays 0.
- R5: `block_start` is 1 exactly while bit 0 of word A is being output, and 0 at all other times.
- R6: `cs_busy` rises in the cycle after word A is loaded. This includes the reload of A at wraparound.
- R7: `cs_busy` falls in the cycle after word F is loaded. It stays 0 while F goes out.
- R8: `tx_en` is sampled only at strobe edges. A strobe edge that sees `tx_en` low ends transmission at that frame boundary: from the next cycle the outputs are 0 and the block is idle. The next start begins at bit 0 of A. Dropping `tx_en` and raising it again between strobes has no effect.
- R9: While `cs_en` is low, `cs_bit` and `block_start` are 0 in the same cycle. From the next edge the block is idle with the pointer at A and `cs_busy` at 0. A later start needs a strobe.
- R10: A write with `wr_en` high stores `wr_data` into shadow word `wr_idx` and takes effect the next time that word is loaded. A write on the same edge as the load of that word is too late, so the old value is sent. A write with `wr_idx` of 6 or 7 changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable, sampled at frame strobes |
| cs_en | input | 1 | Channel-status enable |
| frame_strobe | input | 1 | One-cycle pulse per frame boundary |
| wr_en | input | 1 | Shadow word write strobe |
| wr_idx | input | 3 | Shadow word index, 0 = A to 5 = F |
| wr_data | input | 32 | Shadow word write value |
| cs_bit | output | 1 | Channel-status bit for the current frame |
| block_start | output | 1 | High while bit 0 of word A is output |
| cs_busy | output | 1 | Status block transmission in progress |

## Verification
Two events can fall on the same edge: a register write to a shadow word, and the load of that same word into the shifter.

The bench provokes this collision from its own model position. It waits until bit 31 of word A is going out. It then drives the next strobe together with a write to word B. A second collision is made on word A at wraparound. The reference model loads the old value and applies the write afterwards. The per-cycle comparison then expects the old B for that pass and the new B on the following pass.

A second overlap is also exercised: a strobe edge that both loads a new word and sees `tx_en` low. In that case stopping must win.

// File: rtl/cs_shift_pkg.sv
package cs_shift_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;

    // Index of the word that follows idx in a ring of n words.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/cs_shadow_bank.sv
module cs_shadow_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 6,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] bank_d;
    logic [NUM_WORDS-1:0][WORD_W-1:0] bank_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_comb begin
            bank_d[g] = bank_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                bank_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else begin
                bank_q[g] <= bank_d[g];
            end
        end
    end

    // Read returns the registered value, so a write on the load edge is not seen.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_word = bank_q[i];
            end
        end
    end

endmodule

// File: rtl/cs_bit_sequencer.sv
module cs_bit_sequencer
    import cs_shift_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 6,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              cs_en,
    input  logic              frame_strobe,
    input  logic [WORD_W-1:0] load_word,
    output logic [IDX_W-1:0]  load_idx,
    output logic              load_pulse,
    output logic              halt_pulse,
    output logic              run,
    output logic              cs_bit,
    output logic              block_start
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        seq_mode_e         mode;
        logic [IDX_W-1:0]  ptr;
        logic [BIT_W-1:0]  bitpos;
        logic [WORD_W-1:0] shreg;
    } seq_state_t;

    seq_state_t seq_d, seq_q;
    logic [IDX_W-1:0] next_ptr;

    always_comb begin
        next_ptr   = IDX_W'(ring_next(int'(seq_q.ptr), NUM_WORDS));
        seq_d      = seq_q;
        load_pulse = 1'b0;
        halt_pulse = 1'b0;
        load_idx   = (seq_q.mode == SEQ_IDLE) ? '0 : next_ptr;

        unique case (seq_q.mode)
            SEQ_IDLE: begin
                if (frame_strobe && tx_en && cs_en) begin
                    load_pulse   = 1'b1;
                    seq_d.mode   = SEQ_RUN;
                    seq_d.ptr    = '0;
                    seq_d.bitpos = '0;
                    seq_d.shreg  = load_word;
                end
            end
            SEQ_RUN: begin
                if (!cs_en || (frame_strobe && !tx_en)) begin
                    // Stop wins over any load due on this edge.
                    halt_pulse   = 1'b1;
                    seq_d.mode   = SEQ_IDLE;
                    seq_d.ptr    = '0;
                    seq_d.bitpos = '0;
                    seq_d.shreg  = '0;
                end else if (frame_strobe) begin
                    if (seq_q.bitpos == LAST_BIT) begin
                        load_pulse   = 1'b1;
                        seq_d.ptr    = next_ptr;
                        seq_d.bitpos = '0;
                        seq_d.shreg  = load_word;
                    end else begin
                        seq_d.bitpos = seq_q.bitpos + 1'b1;
                        seq_d.shreg  = seq_q.shreg >> 1;
                    end
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{mode: SEQ_IDLE, ptr: '0, bitpos: '0, shreg: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run         = (seq_q.mode == SEQ_RUN);
    assign cs_bit      = run && cs_en && seq_q.shreg[0];
    assign block_start = run && cs_en && (seq_q.ptr == '0) && (seq_q.bitpos == '0);

endmodule

// File: rtl/cs_busy_tracker.sv
module cs_busy_tracker #(
    parameter int NUM_WORDS = 6,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_en,
    input  logic             load_pulse,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             halt_pulse,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic busy;
    } busy_state_t;

    busy_state_t bs_d, bs_q;

    always_comb begin
        bs_d = bs_q;
        if (halt_pulse || !cs_en) begin
            bs_d.busy = 1'b0;
        end else if (load_pulse && (load_idx == '0)) begin
            bs_d.busy = 1'b1;
        end else if (load_pulse && (load_idx == LAST_IDX)) begin
            bs_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bs_q <= '{busy: 1'b0};
        end else begin
            bs_q <= bs_d;
        end
    end

    assign busy = bs_q.busy;

endmodule

// File: rtl/cs_block_shifter.sv
module cs_block_shifter #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 6,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              cs_en,
    input  logic              frame_strobe,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic              cs_bit,
    output logic              block_start,
    output logic              cs_busy
);

    logic [IDX_W-1:0]  load_idx;
    logic [WORD_W-1:0] load_word;
    logic              load_pulse;
    logic              halt_pulse;
    logic              seq_run;

    cs_shadow_bank #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS)
    ) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_idx (load_idx),
        .rd_word(load_word)
    );

    cs_bit_sequencer #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .cs_en       (cs_en),
        .frame_strobe(frame_strobe),
        .load_word   (load_word),
        .load_idx    (load_idx),
        .load_pulse  (load_pulse),
        .halt_pulse  (halt_pulse),
        .run         (seq_run),
        .cs_bit      (cs_bit),
        .block_start (block_start)
    );

    cs_busy_tracker #(
        .NUM_WORDS(NUM_WORDS)
    ) busy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_en     (cs_en),
        .load_pulse(load_pulse),
        .load_idx  (load_idx),
        .halt_pulse(halt_pulse),
        .busy      (cs_busy)
    );

endmodule

// File: rtl/cs_shift_chk.sv
module cs_shift_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic cs_en,
    input logic frame_strobe,
    input logic cs_bit,
    input logic block_start,
    input logic cs_busy,
    input logic run
);

    AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_strobe && cs_en) |=> (!cs_en || $stable(cs_bit))); // R2

    AST_START_LOADS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && frame_strobe && tx_en && cs_en) |=> (block_start || !cs_en)); // R4

    AST_BUSY_RISE_AT_A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_busy) |-> (block_start || !cs_en)); // R6

    AST_BUSY_FALL_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_busy) |-> ($past(frame_strobe) || !$past(cs_en))); // R7

    AST_STOP_ON_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !tx_en) |=> (!cs_busy && !cs_bit && !block_start)); // R8

    AST_CS_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_en |=> (!cs_busy && !run)); // R9

    AST_CS_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_en |-> (!cs_bit && !block_start)); // R9

endmodule

bind cs_block_shifter cs_shift_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .cs_en       (cs_en),
    .frame_strobe(frame_strobe),
    .cs_bit      (cs_bit),
    .block_start (block_start),
    .cs_busy     (cs_busy),
    .run         (seq_run)
);

// File: tb/cs_block_shifter_tb_top.sv
`timescale 1ns/1ps
module cs_block_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        cs_en = 1'b0;
    logic        frame_strobe = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        cs_bit;
    logic        block_start;
    logic        cs_busy;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [31:0] m_shadow [6];
    logic [31:0] m_cur;
    int          m_ptr;
    int          m_bit;
    bit          m_run;
    bit          m_busy;

    always #5 clk = ~clk;

    cs_block_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en),
        .frame_strobe(frame_strobe), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .cs_bit(cs_bit), .block_start(block_start),
        .cs_busy(cs_busy)
    );

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_shadow[i] = 32'h0;
            m_cur = 32'h0; m_ptr = 0; m_bit = 0; m_run = 0; m_busy = 0;
        end else begin
            if (m_run) begin
                if (!cs_en || (frame_strobe && !tx_en)) begin
                    m_run = 0; m_ptr = 0; m_bit = 0; m_busy = 0;
                end else if (frame_strobe) begin
                    if (m_bit == 31) begin
                        m_bit = 0;
                        m_ptr = (m_ptr + 1) % 6;
                        m_cur = m_shadow[m_ptr];
                        if (m_ptr == 0) m_busy = 1;
                        if (m_ptr == 5) m_busy = 0;
                    end else begin
                        m_bit = m_bit + 1;
                    end
                end
            end else if (frame_strobe && tx_en && cs_en) begin
                m_run = 1; m_ptr = 0; m_bit = 0; m_cur = m_shadow[0]; m_busy = 1;
            end else if (!cs_en) begin
                m_busy = 0;
            end
            if (wr_en && wr_idx < 6) m_shadow[wr_idx] = wr_data;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Compare shortly before each rising edge, after inputs have settled.
    always @(negedge clk) begin
        logic  e_bit, e_bs;
        string busy_req;
        #4;
        if (!done) begin
            e_bit = (m_run && cs_en) ? m_cur[m_bit] : 1'b0;
            e_bs  = m_run && cs_en && m_ptr == 0 && m_bit == 0;
            if (cur_req == "R1" || cur_req == "R8" || cur_req == "R9") busy_req = cur_req;
            else busy_req = m_busy ? "R6" : "R7";
            check(cur_req, "cs_bit", cs_bit, e_bit);
            check((cur_req == "R1") ? "R1" : "R5", "block_start", block_start, e_bs);
            check(busy_req, "cs_busy", cs_busy, m_busy);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL R2 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic frames(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            frame_strobe = 1'b1; tick();
            frame_strobe = 1'b0;
            for (int j = 0; j < gap; j++) tick();
        end
    endtask

    task automatic write_word(input int idx, input logic [31:0] val);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = val; tick();
        wr_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (2) tick();

        // R10: load shadow words while idle, plus writes to unused indices
        cur_req = "R10";
        write_word(0, 32'hA5C3_0F01);
        write_word(1, 32'h1234_5678);
        write_word(2, 32'hFFFF_0000);
        write_word(3, 32'h8000_0001);
        write_word(4, 32'h0F0F_F0F0);
        write_word(5, 32'hDEAD_BEEF);
        write_word(6, 32'hFFFF_FFFF);
        write_word(7, 32'hFFFF_FFFF);

        // R4: strobes with one enable low start nothing
        cur_req = "R4";
        tx_en = 1'b1; frames(3, 3);
        tx_en = 1'b0; cs_en = 1'b1; frames(3, 3);
        tx_en = 1'b1; frames(1, 3);

        // R2: first word bit by bit
        cur_req = "R2";
        frames(31, 3);
        // R3: remaining words, wraparound and second block
        cur_req = "R3";
        frames(161 + 40, 2);

        // R10: write to B on the very edge that loads B
        cur_req = "R10";
        while (!(m_ptr == 0 && m_bit == 31)) frames(1, 2);
        frame_strobe = 1'b1; wr_en = 1'b1; wr_idx = 3'd1; wr_data = 32'h5A5A_00FF; tick();
        frame_strobe = 1'b0; wr_en = 1'b0; tick();
        write_word(3, 32'h7777_1111);
        frames(200, 2);
        // write to A exactly on the wraparound load of A
        while (!(m_ptr == 5 && m_bit == 31)) frames(1, 1);
        frame_strobe = 1'b1; wr_en = 1'b1; wr_idx = 3'd0; wr_data = 32'h0000_FFFE; tick();
        frame_strobe = 1'b0; wr_en = 1'b0; tick();
        frames(40, 0);   // R2: back-to-back strobes

        // R8: tx_en pulse low between strobes has no effect
        cur_req = "R8";
        tx_en = 1'b0; tick(); tx_en = 1'b1; tick();
        frames(10, 2);
        // R8: tx_en low at a strobe that also loads a word
        while (m_bit != 31) frames(1, 1);
        tx_en = 1'b0; frames(1, 3);
        frames(4, 2);
        tx_en = 1'b1;
        cur_req = "R4";
        frames(40, 2);

        // R9: cs_en drop mid-block, then recovery
        cur_req = "R9";
        cs_en = 1'b0; repeat (5) tick();
        frames(5, 2);
        cs_en = 1'b1; repeat (3) tick();
        frames(200, 1);
        cs_en = 1'b0; tick(); cs_en = 1'b1;
        frames(20, 1);

        repeat (3) tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule